// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps track of loads that a compiler has moved above stores that might write the same bytes. When such a hoisted load executes, it also sends the block its destination register number, its byte address and its access size. The load itself goes ahead unchanged. The table is only a side record and never stalls or replaces the memory access.

Every store sends its address and size to the table. Any recorded entry whose byte range overlaps the store's byte range is dropped. At the point where the load originally sat in program order, a check names the destination register. The table answers pass if a valid entry for that register is still held, and fail otherwise. On a fail, software runs recovery code, which is outside this block.

A flush input empties the whole table, for example on a context switch. The table has 32 fully associative entries. When it is full, a round-robin pointer picks the entry to replace.

Top module: `spec_load_table`

## Requirements
- R1: After an insert (`ld_valid`) for register r, a later check of r reports pass while no store has overlapped the recorded range.
- R2: A check of a register that has no valid entry reports fail. After reset the table holds no valid entry.
- R3: A store invalidates every entry where `entry_lo < st_hi` and `st_lo < entry_hi`, where hi = address + byte count. Ranges that only touch at an edge do not overlap, and entries that do not overlap are kept.
- R4: A check asserts `chk_ack` one cycle later, with `chk_pass` giving the result. The result reflects the table contents before any insert, store or flush in the same cycle. A check does not remove its entry.
- R5: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 are treated as 16 bytes. Load and store sizes use the same coding.
- R6: An insert for a register that already has a valid entry overwrites that entry. Afterwards, only the new range decides invalidation.
- R7: An insert for a new register takes the lowest-numbered free entry. When all entries are valid, it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one (wrapping) on each such replacement.
- R8: `flush_all` invalidates every entry. An insert in the same cycle is dropped.
- R9: When a store and an insert happen in the same cycle, the store is applied first. The newly inserted entry is valid afterwards, even if its range overlaps the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry |
| ld_valid | input | 1 | Hoisted load insert request |
| ld_reg | input | RW (7) | Destination register of the load |
| ld_addr | input | AW (32) | Load byte address |
| ld_size | input | 3 | Load size code |
| st_valid | input | 1 | Store snoop request |
| st_addr | input | AW (32) | Store byte address |
| st_size | input | 3 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_reg | input | RW (7) | Register being checked |
| chk_ack | output | 1 | Check response valid, one cycle after the request |
| chk_pass | output | 1 | 1 when a valid entry for the checked register exists |

## Verification
The overlap rule is swept over every load size against every store size. For each pair, the store's start address slides from well below to well above the recorded range. This separates strict overlap from edge-touching and disjoint ranges, and catches any error in the size coding or in an inclusive or exclusive bound. Separate directed patterns fill all 32 entries and keep inserting, so that pointer-based replacement shows up as specific registers failing their checks. Other patterns re-insert a register at a new address and then store to the old one, which tells overwrite apart from duplicate allocation. Same-cycle combinations (store with insert, check with insert, flush with insert) pin down the order in which the updates apply.

// File: rtl/spec_load_pkg.sv
package spec_load_pkg;

    localparam int SZW = 3;

    // Byte count of a size code; codes above 4 saturate at 16 bytes.
    function automatic logic [4:0] size_bytes(input logic [SZW-1:0] code);
        logic [4:0] n;
        unique case (code)
            3'd0:    n = 5'd1;
            3'd1:    n = 5'd2;
            3'd2:    n = 5'd4;
            3'd3:    n = 5'd8;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/slt_cmp.sv
module slt_cmp #(
    parameter int AW = 32,
    parameter int RW = 7
) (
    input  logic          e_valid,
    input  logic [RW-1:0] e_reg,
    input  logic [AW:0]   e_lo,
    input  logic [AW:0]   e_hi,
    input  logic [RW-1:0] ld_reg,
    input  logic [RW-1:0] chk_reg,
    input  logic [AW:0]   st_lo,
    input  logic [AW:0]   st_hi,
    output logic          ld_hit,
    output logic          chk_hit,
    output logic          st_hit
);
    // Half-open ranges [lo,hi) overlap when each starts below the other's end.
    always_comb begin
        ld_hit  = e_valid && (e_reg == ld_reg);
        chk_hit = e_valid && (e_reg == chk_reg);
        st_hit  = e_valid && (e_lo < st_hi) && (st_lo < e_hi);
    end
endmodule

// File: rtl/slt_victim.sv
module slt_victim #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [N-1:0] hit_vec,
    input  logic [N-1:0] free_vec,
    output logic [N-1:0] wr_vec
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] free_idx;
    logic          use_ptr;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = PW'(i);
        end
    end

    always_comb begin
        wr_vec  = '0;
        use_ptr = 1'b0;
        if (go) begin
            if (|hit_vec) begin
                wr_vec = hit_vec;
            end else if (|free_vec) begin
                wr_vec[free_idx] = 1'b1;
            end else begin
                wr_vec[ptr_q] = 1'b1;
                use_ptr       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (use_ptr) begin
            ptr_q <= (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R7: an accepted insert writes exactly one entry.
    p_one_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $countones(wr_vec) == 1);

    // R7: the replacement pointer moves only after a replacement.
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !use_ptr |=> $stable(ptr_q));
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
    parameter int N  = 32,
    parameter int AW = 32,
    parameter int RW = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush_all,
    input  logic                           ld_valid,
    input  logic [RW-1:0]                  ld_reg,
    input  logic [AW-1:0]                  ld_addr,
    input  logic [spec_load_pkg::SZW-1:0]  ld_size,
    input  logic                           st_valid,
    input  logic [AW-1:0]                  st_addr,
    input  logic [spec_load_pkg::SZW-1:0]  st_size,
    input  logic                           chk_valid,
    input  logic [RW-1:0]                  chk_reg,
    output logic                           chk_ack,
    output logic                           chk_pass
);
    import spec_load_pkg::*;

    logic [N-1:0]  valid_q;
    logic [RW-1:0] reg_q [N];
    logic [AW:0]   lo_q  [N];
    logic [AW:0]   hi_q  [N];

    logic [N-1:0]  ld_hit_vec, chk_hit_vec, st_hit_vec;
    logic [N-1:0]  kill_vec, post_valid, wr_vec;
    logic [AW:0]   st_lo, st_hi, ld_lo, ld_hi;
    logic          ld_go;
    logic          ack_q, pass_q;

    always_comb begin
        st_lo = {1'b0, st_addr};
        st_hi = st_lo + (AW+1)'(size_bytes(st_size));
        ld_lo = {1'b0, ld_addr};
        ld_hi = ld_lo + (AW+1)'(size_bytes(ld_size));
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            slt_cmp #(.AW(AW), .RW(RW)) u_cmp (
                .e_valid (valid_q[g]),
                .e_reg   (reg_q[g]),
                .e_lo    (lo_q[g]),
                .e_hi    (hi_q[g]),
                .ld_reg  (ld_reg),
                .chk_reg (chk_reg),
                .st_lo   (st_lo),
                .st_hi   (st_hi),
                .ld_hit  (ld_hit_vec[g]),
                .chk_hit (chk_hit_vec[g]),
                .st_hit  (st_hit_vec[g])
            );
        end
    endgenerate

    // Store snoop applies before the insert of the same cycle.
    always_comb begin
        kill_vec   = st_valid ? st_hit_vec : '0;
        post_valid = valid_q & ~kill_vec;
        ld_go      = ld_valid && !flush_all;
    end

    slt_victim #(.N(N)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (ld_go),
        .hit_vec  (ld_hit_vec),
        .free_vec (~post_valid),
        .wr_vec   (wr_vec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush_all) begin
            valid_q <= '0;
        end else begin
            valid_q <= post_valid | wr_vec;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (wr_vec[i]) begin
                reg_q[i] <= ld_reg;
                lo_q[i]  <= ld_lo;
                hi_q[i]  <= ld_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            ack_q  <= chk_valid;
            pass_q <= chk_valid && (|chk_hit_vec);
        end
    end

    always_comb begin
        chk_ack  = ack_q;
        chk_pass = pass_q;
    end

    // R6: never two valid entries for one register.
    p_unique_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_hit_vec));

    // R8: flush leaves nothing valid.
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> valid_q == '0);

    // R3: overlapped entries are gone unless rewritten in that cycle.
    p_store_kills_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !flush_all) |=> (valid_q & $past(st_hit_vec) & ~$past(wr_vec)) == '0);

    // R9: an accepted insert is valid on the next cycle.
    p_insert_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> (valid_q & $past(wr_vec)) != '0);

    // R4: response arrives one cycle after a check and only then.
    p_ack_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_ack);
    p_no_stray_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_ack && !chk_pass);
endmodule

// File: tb/sim_spec_load_table.sv
module sim_spec_load_table;
    localparam int N  = 32;
    localparam int AW = 32;
    localparam int RW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_all = 1'b0;
    logic          ld_valid = 1'b0;
    logic [RW-1:0] ld_reg = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [2:0]    ld_size = '0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [2:0]    st_size = '0;
    logic          chk_valid = 1'b0;
    logic [RW-1:0] chk_reg = '0;
    logic          chk_ack, chk_pass;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spec_load_table #(.N(N), .AW(AW), .RW(RW)) u0 (
        .clk, .rst_n, .flush_all, .ld_valid, .ld_reg, .ld_addr, .ld_size,
        .st_valid, .st_addr, .st_size, .chk_valid, .chk_reg, .chk_ack, .chk_pass
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        flush_all = 0; ld_valid = 0; st_valid = 0; chk_valid = 0;
    endtask

    task automatic cmp(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic ins(input int r, input int a, input int s);
        ld_valid = 1; ld_reg = RW'(r); ld_addr = AW'(a); ld_size = 3'(s);
        step(); clear_in();
    endtask

    task automatic store(input int a, input int s);
        st_valid = 1; st_addr = AW'(a); st_size = 3'(s);
        step(); clear_in();
    endtask

    task automatic flush();
        flush_all = 1; step(); clear_in();
    endtask

    task automatic check(input string req, input int r, input logic exp);
        chk_valid = 1; chk_reg = RW'(r);
        step(); clear_in();
        cmp(req, chk_ack, 1'b1);
        cmp(req, chk_pass, exp);
    endtask

    function automatic int nbytes(input int code);
        return (code >= 4) ? 16 : (1 << code);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R4: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R2 reset state: no response without request, empty table
        cmp("R4 idle ack", chk_ack, 1'b0);
        check("R2 empty after reset", 0, 1'b0);
        check("R2 empty after reset", 100, 1'b0);

        // R1 basic insert, R4 not consumed
        ins(9, 5000, 3);
        check("R1 insert then check", 9, 1'b1);
        check("R4 check repeats", 9, 1'b1);
        check("R2 other reg", 10, 1'b0);

        // R3/R5 sweep of overlap rule
        for (int sl = 0; sl < 5; sl++) begin
            for (int ss = 0; ss < 5; ss++) begin
                for (int off = -20; off <= 20; off++) begin
                    int sa;
                    logic ovl;
                    sa = 1000 + off;
                    ovl = (1000 < sa + nbytes(ss)) && (sa < 1000 + nbytes(sl));
                    flush();
                    ins(3, 1000, sl);
                    store(sa, ss);
                    check("R3 R5 overlap sweep", 3, !ovl);
                end
            end
        end

        // R5 codes above 4 mean 16 bytes
        flush();
        ins(4, 2000, 7);
        store(2015, 0);
        check("R5 code7 last byte", 4, 1'b0);
        ins(4, 2000, 6);
        store(2016, 5);
        check("R5 code6 edge", 4, 1'b1);

        // R6 overwrite
        flush();
        ins(5, 3000, 2);
        ins(5, 3100, 2);
        store(3000, 2);
        check("R6 old range ignored", 5, 1'b1);
        store(3102, 0);
        check("R6 new range used", 5, 1'b0);

        // R9 store and insert same cycle
        flush();
        ld_valid = 1; ld_reg = 7; ld_addr = 4000; ld_size = 2;
        st_valid = 1; st_addr = 4000; st_size = 2;
        step(); clear_in();
        check("R9 insert survives same-cycle store", 7, 1'b1);

        // R4 check sees pre-update state
        chk_valid = 1; chk_reg = 8;
        ld_valid = 1; ld_reg = 8; ld_addr = 4100; ld_size = 0;
        step(); clear_in();
        cmp("R4 same-cycle insert not seen", chk_pass, 1'b0);
        check("R4 insert visible after", 8, 1'b1);

        // R8 flush clears and drops same-cycle insert
        flush();
        check("R8 flush clears", 7, 1'b0);
        check("R8 flush clears", 8, 1'b0);
        flush_all = 1; ld_valid = 1; ld_reg = 11; ld_addr = 4200; ld_size = 0;
        step(); clear_in();
        check("R8 insert dropped on flush", 11, 1'b0);

        // R7 fill then round-robin replacement
        for (int r = 0; r < N; r++) ins(r, 10000 + 64 * r, 3);
        check("R7 full table keeps reg0", 0, 1'b1);
        check("R7 full table keeps reg31", 31, 1'b1);
        ins(40, 20000, 3);
        check("R7 victim entry0 evicted", 0, 1'b0);
        check("R7 reg1 kept", 1, 1'b1);
        check("R7 new reg placed", 40, 1'b1);
        ins(41, 20100, 3);
        check("R7 victim entry1 evicted", 1, 1'b0);
        check("R7 reg2 kept", 2, 1'b1);
        // R7 a freed slot is reused before replacement
        store(10000 + 64 * 5, 0);
        check("R3 reg5 invalidated", 5, 1'b0);
        ins(42, 21000, 3);
        check("R7 reg2 survives free reuse", 2, 1'b1);
        check("R7 reg42 placed", 42, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule